// File: doc/BRIEF.md
# Link Activity Power Manager

This block decides when a copper PHY may drop into a low-power condition, based on whether energy is present on the media. While the mode is enabled and no energy is seen, it alternates between a sleep state and a partner wake-up state. Each visit lasts a fixed number of prescaled ticks. On every entry into the wake-up state it asks an external burst generator for a burst of link pulses. Energy from either of these two states moves it to normal operation.

In normal operation with auto-negotiation on, a link that stays down for a full timeout sends the block back to sleep. Once auto-negotiation has been seen off during normal operation, the block stays in normal operation regardless of the link. Clearing the enable bit forces normal operation and releases power-down. Both intervals are counted in ticks of an external prescaled strobe and are set by parameters.

Top module: `link_power_mgr`

## Requirements
- R1: While reset is asserted, and after it is released, `pmState` is 0 (sleep), `powerDown` is 1 and `wakeBurst` is 0.
- R2: `pmState` uses these codes: 0 is sleep, 1 is wake-up and 2 is normal. Code 3 never appears. `powerDown` is 1 exactly when `pmState` is 0.
- R3: While enabled with no energy, the block toggles between sleep and wake-up. The toggle happens on the clock edge of the PERIOD_TICKS-th `tick` counted since it entered the current state. Cycles without `tick` do not advance the count.
- R4: `wakeBurst` is high for exactly the first cycle of each visit to the wake-up state.
- R5: `energyDet` in sleep or wake-up moves the block to normal on the next edge. This takes priority over a period expiring in the same cycle.
- R6: In normal operation with auto-negotiation on and the link down, the block enters sleep on the edge of the LINK_TIMEOUT_TICKS-th consecutive `tick` with the link down.
- R7: If the link comes back up before the timeout completes, the timeout count restarts, and a full LINK_TIMEOUT_TICKS ticks with the link down are needed again.
- R8: With `enable` low, the block is in normal state with `powerDown` at 0 from the next edge on, whatever its previous state.
- R9: With auto-negotiation off, the block still alternates between the sleep states. Once it reaches normal operation it stays there when the link is down.
- R10: After auto-negotiation has been seen off in normal operation, the block stays in normal operation even if auto-negotiation is switched back on and the link is down. This lasts until `enable` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Power management mode enable |
| anEnable | input | 1 | Auto-negotiation enabled |
| energyDet | input | 1 | Signal energy present on the media |
| linkUp | input | 1 | Link status |
| tick | input | 1 | Prescaled one-cycle timing strobe |
| pmState | output | 2 | Current state: 0 sleep, 1 wake-up, 2 normal |
| powerDown | output | 1 | Power-down control to the PHY |
| wakeBurst | output | 1 | One-cycle request for a wake burst |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `tick` is a strobe sampled once per cycle, and that `energyDet` and `linkUp` are plain levels with no other timing relation to each other. The bench meets these assumptions by changing every input only on the falling edge, holding each value for a full cycle, and raising `tick` for single cycles. The bench shortens both intervals through parameters so that every expiry, restart and priority case is reached within a few cycles.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    PM_SLEEP  = 2'd0,
    PM_WAKE   = 2'd1,
    PM_ACTIVE = 2'd2
  } pmState_e;

  // Strobes from the control FSM to the tick counters
  typedef struct packed {
    logic clrPeriod;
    logic runPeriod;
    logic clrLink;
    logic runLink;
  } pmStrobe_t;

endpackage

// File: rtl/lpm_tickcnt.sv
module lpm_tickcnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic done
);

  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  // done is the last counted tick; the caller gates it with its own run strobe
  assign done = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lpm_timer.sv
module lpm_timer
  import lpm_pkg::*;
#(
  parameter int PERIOD_TICKS       = 2000,
  parameter int LINK_TIMEOUT_TICKS = 1500
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  pmStrobe_t strobe,
  output logic      periodDone,
  output logic      linkExpired
);

  lpm_tickcnt #(.LIMIT(PERIOD_TICKS)) i_periodCnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (strobe.clrPeriod),
    .run  (strobe.runPeriod),
    .tick (tick),
    .done (periodDone)
  );

  lpm_tickcnt #(.LIMIT(LINK_TIMEOUT_TICKS)) i_linkCnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (strobe.clrLink),
    .run  (strobe.runLink),
    .tick (tick),
    .done (linkExpired)
  );

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      anEnable,
  input  logic      energyDet,
  input  logic      linkUp,
  input  logic      periodDone,
  input  logic      linkExpired,
  output pmStrobe_t strobe,
  output pmState_e  stateQ,
  output logic      wakeBurst
);

  pmState_e nextState;
  logic     holdQ;

  always_comb begin
    nextState = stateQ;
    strobe    = '0;
    case (stateQ)
      PM_SLEEP, PM_WAKE: begin
        if (energyDet) begin
          nextState = PM_ACTIVE;
        end else begin
          strobe.runPeriod = 1'b1;
          if (periodDone) begin
            nextState = (stateQ == PM_SLEEP) ? PM_WAKE : PM_SLEEP;
          end
        end
      end
      PM_ACTIVE: begin
        if (anEnable && !holdQ && !linkUp) begin
          strobe.runLink = 1'b1;
          if (linkExpired) nextState = PM_SLEEP;
        end
      end
      default: nextState = PM_SLEEP;
    endcase
    if (!enable) begin
      nextState        = PM_ACTIVE;
      strobe.runPeriod = 1'b0;
      strobe.runLink   = 1'b0;
    end
    strobe.clrPeriod = !strobe.runPeriod;
    strobe.clrLink   = !strobe.runLink;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ    <= PM_SLEEP;
      holdQ     <= 1'b0;
      wakeBurst <= 1'b0;
    end else begin
      stateQ    <= nextState;
      wakeBurst <= (nextState == PM_WAKE) && (stateQ != PM_WAKE);
      if (!enable) begin
        holdQ <= 1'b0;
      end else if (stateQ == PM_ACTIVE && !anEnable) begin
        holdQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/link_power_mgr.sv
module link_power_mgr
  import lpm_pkg::*;
#(
  parameter int PERIOD_TICKS       = 2000,
  parameter int LINK_TIMEOUT_TICKS = 1500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       anEnable,
  input  logic       energyDet,
  input  logic       linkUp,
  input  logic       tick,
  output logic [1:0] pmState,
  output logic       powerDown,
  output logic       wakeBurst
);

  pmStrobe_t strobe;
  pmState_e  stateQ;
  logic      periodDone;
  logic      linkExpired;

  lpm_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .anEnable   (anEnable),
    .energyDet  (energyDet),
    .linkUp     (linkUp),
    .periodDone (periodDone),
    .linkExpired(linkExpired),
    .strobe     (strobe),
    .stateQ     (stateQ),
    .wakeBurst  (wakeBurst)
  );

  lpm_timer #(
    .PERIOD_TICKS      (PERIOD_TICKS),
    .LINK_TIMEOUT_TICKS(LINK_TIMEOUT_TICKS)
  ) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .strobe     (strobe),
    .periodDone (periodDone),
    .linkExpired(linkExpired)
  );

  assign pmState   = stateQ;
  assign powerDown = (stateQ == PM_SLEEP);

endmodule

// File: rtl/link_power_mgr_chk.sv
module link_power_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       anEnable,
  input logic       energyDet,
  input logic       linkUp,
  input logic       tick,
  input logic [1:0] pmState,
  input logic       wakeBurst
);

  assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pmState != 2'd3);

  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !energyDet && !tick && pmState != 2'd2) |=> $stable(pmState));

  assert_burst_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wakeBurst) |-> (pmState == 2'd1 && $past(pmState) != 2'd1));

  assert_burst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wakeBurst |=> !wakeBurst);

  assert_energy_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && energyDet && pmState != 2'd2) |=> pmState == 2'd2);

  assert_no_early_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pmState == 2'd2 && (linkUp || !tick)) |=> pmState != 2'd0);

  assert_disable_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pmState == 2'd2);

  assert_forced_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !anEnable && pmState == 2'd2) |=> pmState == 2'd2);

endmodule

bind link_power_mgr link_power_mgr_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .anEnable (anEnable),
  .energyDet(energyDet),
  .linkUp   (linkUp),
  .tick     (tick),
  .pmState  (pmState),
  .wakeBurst(wakeBurst)
);

// File: tb/test_link_power_mgr.sv
`timescale 1ns/1ps
module test_link_power_mgr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic       anEnable = 1'b1;
  logic       energyDet = 1'b0;
  logic       linkUp = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] pmState;
  logic       powerDown;
  logic       wakeBurst;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  link_power_mgr #(.PERIOD_TICKS(3), .LINK_TIMEOUT_TICKS(2)) i_link_power_mgr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .anEnable(anEnable),
    .energyDet(energyDet), .linkUp(linkUp), .tick(tick),
    .pmState(pmState), .powerDown(powerDown), .wakeBurst(wakeBurst)
  );

  // Row: {tag[3:0], enable, anEnable, energyDet, linkUp, tick, expState[1:0], expPd, expWb}
  // Inputs are held for one clock; the expected outputs are those after that edge.
  localparam int NROWS = 35;
  localparam logic [12:0] VEC [NROWS] = '{
    {4'd3,  5'b11000, 2'd0, 1'b1, 1'b0},  // no tick, no advance
    {4'd3,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd3,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd4,  5'b11001, 2'd1, 1'b0, 1'b1},  // third tick: wake, burst
    {4'd4,  5'b11000, 2'd1, 1'b0, 1'b0},  // burst lasts one cycle
    {4'd3,  5'b11001, 2'd1, 1'b0, 1'b0},
    {4'd3,  5'b11001, 2'd1, 1'b0, 1'b0},
    {4'd2,  5'b11001, 2'd0, 1'b1, 1'b0},  // back to sleep, power down
    {4'd3,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd5,  5'b11101, 2'd2, 1'b0, 1'b0},  // energy
    {4'd6,  5'b11011, 2'd2, 1'b0, 1'b0},
    {4'd6,  5'b11001, 2'd2, 1'b0, 1'b0},  // link down tick 1
    {4'd7,  5'b11011, 2'd2, 1'b0, 1'b0},  // link back: restart
    {4'd7,  5'b11001, 2'd2, 1'b0, 1'b0},
    {4'd7,  5'b11000, 2'd2, 1'b0, 1'b0},
    {4'd6,  5'b11001, 2'd0, 1'b1, 1'b0},  // timeout
    {4'd3,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd8,  5'b01000, 2'd2, 1'b0, 1'b0},  // disable
    {4'd8,  5'b01001, 2'd2, 1'b0, 1'b0},
    {4'd6,  5'b11001, 2'd2, 1'b0, 1'b0},
    {4'd6,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd9,  5'b10001, 2'd0, 1'b1, 1'b0},  // autoneg off still alternates
    {4'd9,  5'b10001, 2'd0, 1'b1, 1'b0},
    {4'd9,  5'b10001, 2'd1, 1'b0, 1'b1},
    {4'd9,  5'b10100, 2'd2, 1'b0, 1'b0},
    {4'd9,  5'b10001, 2'd2, 1'b0, 1'b0},
    {4'd10, 5'b11001, 2'd2, 1'b0, 1'b0},  // autoneg back on: still held
    {4'd10, 5'b11001, 2'd2, 1'b0, 1'b0},
    {4'd10, 5'b11001, 2'd2, 1'b0, 1'b0},
    {4'd8,  5'b01000, 2'd2, 1'b0, 1'b0},  // disable releases hold
    {4'd6,  5'b11001, 2'd2, 1'b0, 1'b0},
    {4'd6,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd3,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd3,  5'b11001, 2'd0, 1'b1, 1'b0},
    {4'd5,  5'b11101, 2'd2, 1'b0, 1'b0}   // energy beats period expiry
  };

  function automatic string tagName(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {state,pd,wb} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic e, input logic a, input logic g, input logic l, input logic t);
    enable = e; anEnable = a; energyDet = g; linkUp = l; tick = t;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 in reset", {pmState, powerDown, wakeBurst}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {pmState, powerDown, wakeBurst}, 4'b0010);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();

    for (int i = 0; i < NROWS; i++) begin
      drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      @(negedge clk);
      check(tagName(VEC[i][12:9]), {pmState, powerDown, wakeBurst}, VEC[i][3:0]);
    end

    // R1: reset from normal state returns to sleep
    doReset();

    // R8: disabling from the wake-up state
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
    end
    check("R3 wake reached", {pmState, powerDown, wakeBurst}, 4'b0101);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 wake to normal", {pmState, powerDown, wakeBurst}, 4'b1000);

    // R9: forced mode with energy then link loss never sleeps
    doReset();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
    end
    check("R9 forced no sleep", {pmState, powerDown, wakeBurst}, 4'b1000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule